// File: doc/BRIEF.md
# Asynchronous Byte-Wide Memory Device Port

This block models the device side of a byte-wide asynchronous static memory. A host drives active-low chip select, write strobe and read enable pins together with an address and a byte of write data. The block samples every pin with a fast internal clock through a synchroniser chain. It holds a parameterised storage array and returns the addressed byte on a read. It also produces an enable for an external tristate wrapper, which turns the split `dq_out`/`dq_oe` pair into a shared bidirectional data bus.

A write lasts only while chip select and write strobe are both low. The window opens on whichever of the two falls later and closes on whichever rises first. The byte and address seen on the last sampled cycle of that overlap are committed when it closes. A protect input from a power supervisor blocks all activity. Storage depth is set by `ADDR_W`. The full part has 18 address bits (262,144 bytes); the default is kept smaller so that every build elaborates a small array. There is no flow control: the pins are plain, level-sampled strobes.

Top module: `sram_dev_port`

## Requirements
- R1: After reset, `dq_oe` is 0 and `dq_out` is 0x00 until a read has been sampled.
- R2: When `ce_n`=0, `oe_n`=0, `we_n`=1 and `wp`=0 are held, `dq_oe` goes to 1 and `dq_out` shows the byte stored at `addr` no later than the third rising clock edge after the pins settle.
- R3: With `ce_n`=1 or `oe_n`=1, `dq_oe` is 0.
- R4: A write stores the data and address sampled on the last cycle in which `ce_n` and `we_n` were both low. Earlier values that changed during the window are not stored.
- R5: A write window begins only when both strobes are low. A `we_n` pulse while `ce_n` is high stores nothing. Writes framed by `we_n` (with `ce_n` held low) and writes framed by `ce_n` (with `we_n` held low) both store.
- R6: The window ends at the first strobe to rise. Data changed after that point, while the other strobe is still low, is not stored.
- R7: If `we_n` falls while the outputs are driven, `dq_oe` drops within three clock edges and stays 0 for the whole write window.
- R8: If `ce_n` falls together with or after `we_n`, `dq_oe` stays 0 for the whole cycle, even with `oe_n` low.
- R9: While `wp`=1, `dq_oe` is 0 and no write is stored. A window that `wp` interrupts is discarded.
- R10: In the first cycle that a read is driven right after a write to the same address, `dq_out` already carries the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp | input | 1 | Write protect from the supply supervisor, active high |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data toward the tristate wrapper |
| dq_oe | output | 1 | Drive enable for the tristate wrapper |

## Verification
The bench goes after the edges of the strobe overlap. It changes data mid-window, so a design that latched at the window start would store the stale byte. It raises chip select first and then alters the data, so a design that ended the window on write strobe alone would store the late byte. It pulses write strobe while the chip is deselected, which would produce a spurious write in a design that ignored chip select. It watches `dq_oe` on every cycle while write strobe leads chip select, where a leaky enable would cause bus contention. It also raises protect in the middle of a window; a design that committed on any window close would corrupt the array. Finally, it checks the first driven byte after a write, which a design without the bypass path would return stale.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;
  typedef struct packed {
    logic wp;
    logic ce_n;
    logic we_n;
    logic oe_n;
  } pin_ctl_t;

  localparam int CTL_W = $bits(pin_ctl_t);
  localparam pin_ctl_t CTL_IDLE = '{wp: 1'b1, ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
endpackage

// File: rtl/sram_pin_sync.sv
module sram_pin_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage[0] <= RST_VAL;
        else        stage[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage[i] <= RST_VAL;
        else        stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sram_wr_window.sv
module sram_wr_window #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              we_s,
  input  logic              wp_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] din_s,
  output logic              wr_act,
  output logic              commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic win;

  // overlap of both strobes, vetoed by protect
  assign win = !ce_s && !we_s && !wp_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wr_act <= 1'b0;
    else        wr_act <= win;

  // keep the latest in-window sample; it becomes the committed value
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_addr <= '0;
      wr_data <= '0;
    end else if (win) begin
      wr_addr <= addr_s;
      wr_data <= din_s;
    end

  // closing by a strobe commits; closing by protect discards
  assign commit = wr_act && !win && !wp_s;
endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              fwd;

  assign fwd = wr_en && (wr_addr == rd_addr);

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_data <= fwd ? wr_data : mem[rd_addr];
    end
endmodule

// File: rtl/sram_dev_port.sv
module sram_dev_port
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int PIN_W = CTL_W + ADDR_W + DATA_W;
  localparam logic [PIN_W-1:0] PIN_RST = {CTL_IDLE, {(ADDR_W + DATA_W){1'b0}}};

  pin_ctl_t          ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic              ce_s, we_s, oe_s, wp_s;
  logic              wr_act, commit, rd_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  sram_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({wp, ce_n, we_n, oe_n, addr, din}),
    .q({ctl_s, addr_s, din_s})
  );

  assign wp_s = ctl_s.wp;
  assign ce_s = ctl_s.ce_n;
  assign we_s = ctl_s.we_n;
  assign oe_s = ctl_s.oe_n;

  sram_wr_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_win (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ce_s), .we_s(we_s), .wp_s(wp_s),
    .addr_s(addr_s), .din_s(din_s),
    .wr_act(wr_act), .commit(commit),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // read only with write strobe high: a low write strobe overrides read enable
  assign rd_en = !ce_s && !oe_s && we_s && !wp_s;

  sram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(addr_s),
    .rd_data(dq_out), .rd_vld(dq_oe)
  );
endmodule

// File: rtl/sram_dev_port_chk.sv
module sram_dev_port_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_s,
  input logic wp_s,
  input logic wr_act,
  input logic commit,
  input logic dq_oe
);
  // R7 / R8: never drive the bus inside a write window
  a_r7_no_drive_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |-> !dq_oe);

  // R3: deselected chip leaves the bus released
  a_r3_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    ce_s |=> !dq_oe);

  // R9: protect releases the bus
  a_r9_protect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    wp_s |=> !dq_oe);

  // R9: protect never lets a write through
  a_r9_protect_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wp_s |-> !commit);

  // R4: a commit closes the window
  a_r4_commit_closes: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !wr_act);
endmodule

bind sram_dev_port sram_dev_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .wp_s(wp_s),
  .wr_act(wr_act), .commit(commit), .dq_oe(dq_oe)
);

// File: tb/sram_dev_port_bench.sv
module sram_dev_port_bench;
  localparam int AW = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sram_dev_port #(.ADDR_W(AW), .DATA_W(DW)) u_sram_dev_port (
    .clk(clk), .rst_n(rst_n), .wp(wp), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; step(4);
  endtask

  // write framed by we_n with ce_n held low
  task automatic wr_we(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; din = d; ce_n = 1'b0; oe_n = 1'b1; step(2);
    we_n = 1'b0; step(3);
    we_n = 1'b1; step(2);
    ce_n = 1'b1; step(3);
  endtask

  // write framed by ce_n with we_n held low
  task automatic wr_ce(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; din = d; we_n = 1'b0; oe_n = 1'b1; step(2);
    ce_n = 1'b0; step(3);
    ce_n = 1'b1; step(2);
    we_n = 1'b1; step(3);
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0; step(4);
    chk({req, " drive"}, dq_oe, 1);
    chk({req, " data"}, dq_out, exp);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 oe", dq_oe, 0);
    chk("R1 data", dq_out, 0);
  endtask

  task automatic t_basic();
    wr_we(10'h001, 8'hA5);
    wr_we(10'h3FF, 8'h5A);
    wr_ce(10'h155, 8'hFF);
    wr_ce(10'h2AA, 8'h00);
    rd_chk("R2", 10'h001, 8'hA5);
    rd_chk("R2", 10'h3FF, 8'h5A);
    rd_chk("R5 ce-framed", 10'h155, 8'hFF);
    rd_chk("R5 ce-framed", 10'h2AA, 8'h00);
  endtask

  task automatic t_idle_hiz();
    addr = 10'h001; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; step(5);
    chk("R3 oe high", dq_oe, 0);
    ce_n = 1'b1; oe_n = 1'b0; step(5);
    chk("R3 ce high", dq_oe, 0);
    idle();
  endtask

  task automatic t_last_sample();
    ce_n = 1'b0; addr = 10'h010; din = 8'h11; step(2);
    we_n = 1'b0; step(3);
    din = 8'h22; addr = 10'h011; step(3);
    we_n = 1'b1; step(2); ce_n = 1'b1; step(3);
    rd_chk("R4 final data", 10'h011, 8'h22);
  endtask

  task automatic t_we_deselected();
    wr_we(10'h020, 8'h33);
    addr = 10'h020; din = 8'hCC; ce_n = 1'b1; step(2);
    we_n = 1'b0; step(4); we_n = 1'b1; step(4);
    rd_chk("R5 no write when deselected", 10'h020, 8'h33);
  endtask

  task automatic t_early_end();
    addr = 10'h030; din = 8'h44; ce_n = 1'b0; step(2);
    we_n = 1'b0; step(3);
    ce_n = 1'b1; step(3);
    din = 8'h99; step(3);
    we_n = 1'b1; step(3);
    rd_chk("R6 first rise ends window", 10'h030, 8'h44);
  endtask

  task automatic t_we_kills_drive();
    wr_we(10'h040, 8'h55);
    addr = 10'h040; ce_n = 1'b0; oe_n = 1'b0; step(4);
    chk("R7 driving before", dq_oe, 1);
    din = 8'h66; we_n = 1'b0; step(3);
    for (int i = 0; i < 6; i++) begin
      chk("R7 released in window", dq_oe, 0);
      step(1);
    end
    we_n = 1'b1; step(4);
    chk("R7 stored", dq_out, 8'h66);
    idle();
  endtask

  task automatic t_ce_after_we();
    int seen = 0;
    addr = 10'h050; din = 8'h77; oe_n = 1'b0; we_n = 1'b0; step(3);
    ce_n = 1'b0;
    for (int i = 0; i < 8; i++) begin step(1); seen += int'(dq_oe); end
    ce_n = 1'b1;
    for (int i = 0; i < 3; i++) begin step(1); seen += int'(dq_oe); end
    we_n = 1'b1;
    for (int i = 0; i < 4; i++) begin step(1); seen += int'(dq_oe); end
    chk("R8 never driven", seen, 0);
    idle();
    rd_chk("R8 write took", 10'h050, 8'h77);
  endtask

  task automatic t_protect();
    wr_we(10'h060, 8'h12);
    wp = 1'b1; step(3);
    wr_we(10'h060, 8'hEE);
    addr = 10'h060; ce_n = 1'b0; oe_n = 1'b0; step(5);
    chk("R9 hiz while protected", dq_oe, 0);
    idle(); wp = 1'b0; step(3);
    rd_chk("R9 write blocked", 10'h060, 8'h12);
    addr = 10'h060; din = 8'hDD; ce_n = 1'b0; step(2);
    we_n = 1'b0; step(4);
    wp = 1'b1; step(4);
    we_n = 1'b1; ce_n = 1'b1; step(3);
    wp = 1'b0; step(4);
    rd_chk("R9 window discarded", 10'h060, 8'h12);
  endtask

  task automatic t_forward();
    logic [DW-1:0] first = '0;
    bit got = 1'b0;
    wr_we(10'h070, 8'h01);
    addr = 10'h070; din = 8'hBE; ce_n = 1'b0; oe_n = 1'b0; step(4);
    we_n = 1'b0; step(4);
    we_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step(1);
      if (!got && dq_oe) begin got = 1'b1; first = dq_out; end
    end
    chk("R10 driven", got, 1);
    chk("R10 first byte", first, 8'hBE);
    idle();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_basic();
    t_idle_hiz();
    t_last_sample();
    t_we_deselected();
    t_early_end();
    t_we_kills_drive();
    t_ce_after_we();
    t_protect();
    t_forward();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule